// File: doc/BRIEF.md
# Set-Associative Instruction Cache Controller

This block sits between a processor fetch port and a memory that answers AXI4 read bursts. The processor offers a fetch with a byte address. The controller looks the address up in a two-way set-associative store of tags and instruction words, and returns the addressed word. It raises an accept indication when it takes a request and a valid indication when the word is on the data output. If no way holds the line, the controller fetches the whole line with one incrementing read burst. It writes each beat into the word store and then checks the tags once more before it answers.

The processor can also ask for two maintenance actions. A flush clears every line through a walk over all sets, which is the same walk that follows reset. An invalidate clears one set in all ways. The store holds no dirty data, so both actions only clear valid bits. A victim way is chosen without any record of past use. The lowest-numbered empty way of the set is taken first. If the set is full, the way named by a free-running counter is replaced.

Top module: `icache_ctrl`

## Requirements
- R1: After reset is released, the controller clears one set per clock for LINES clocks. During that walk fetch_accept_o, fetch_valid_o and m_arvalid_o stay low. fetch_accept_o first rises after the LINES-th rising edge.
- R2: On a hit, fetch_valid_o is high in the cycle right after the acceptance edge, with the stored word, and no read burst is issued.
- R3: A miss issues a burst with m_araddr_o aligned to the line (low 5 bits zero, upper bits taken from the request), m_arlen_o = 7 (8 beats), m_arsize_o = 2 (4 bytes per beat) and m_arburst_o = 2'b01 (incrementing). m_rready_o is high at all times.
- R4: Once m_arvalid_o rises it stays high with m_araddr_o unchanged until m_arready_i is sampled high. It then drops, and each miss makes exactly one address handshake.
- R5: Beat k of the burst is stored as word k of the line, and idle cycles between beats are tolerated. Refill ends on the beat that carries m_rlast_i. The requested word appears on fetch_valid_o/fetch_data_o in the cycle after that beat's edge (the re-check cycle).
- R6: fetch_accept_o is low during the walk, while a missed request waits, during the refill and in the re-check cycle. At most one request is outstanding.
- R7: A flush request taken in the lookup state restarts the walk: fetch_accept_o stays low for LINES clocks, and every line cached before then misses afterwards. A read offered in the same cycle as a flush is not accepted.
- R8: An invalidate request clears every way of the set selected by fetch_addr_i bits [10:5], so the next read of a line in that set misses. Other sets keep hitting. A read offered in the same cycle as an invalidate is not accepted.
- R9: Two lines with the same set index and different tags are both resident after their two misses. A third line in that set replaces one of them and then hits.
- R10: A hit response that falls in the same cycle as a flush or invalidate request is still delivered with the correct word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_rd_i | input | 1 | Fetch request |
| fetch_addr_i | input | 32 | Fetch byte address; also selects the set to invalidate |
| fetch_flush_i | input | 1 | Clear the whole cache |
| fetch_inval_i | input | 1 | Clear the set addressed by fetch_addr_i |
| fetch_accept_o | output | 1 | Request taken this cycle |
| fetch_valid_o | output | 1 | Instruction word valid |
| fetch_data_o | output | 32 | Instruction word |
| m_arvalid_o | output | 1 | Read address valid |
| m_arready_i | input | 1 | Read address ready |
| m_araddr_o | output | 32 | Line-aligned burst address |
| m_arlen_o | output | 8 | Beats minus one |
| m_arsize_o | output | 3 | log2 of bytes per beat |
| m_arburst_o | output | 2 | Burst type (incrementing) |
| m_rvalid_i | input | 1 | Read data valid |
| m_rdata_i | input | 32 | Read data beat |
| m_rlast_i | input | 1 | Last beat of the burst |
| m_rready_o | output | 1 | Read data ready (tied high) |

## Verification
A hit response and a maintenance request (flush or invalidate) can fall in the same cycle. The answer to the previous fetch is delivered while the controller decides whether to leave the lookup state. The bench provokes this by raising flush or invalidate, together with a fresh read, at the exact sample where the hit's valid is expected. It then requires the returned word to be correct, accept to stay low, and the maintenance effect to be visible afterwards: a walk of full length, or misses in the cleared set only. Around this, the bench sweeps every set under three tags, with varied address-ready delays and beat gaps.

// File: rtl/icache_pkg.sv
// Shared types for the instruction cache controller.
package icache_pkg;
    typedef enum logic [1:0] {
        ST_WALK  = 2'd0,  // clearing valid bits, one set per clock
        ST_LOOK  = 2'd1,  // tag lookup, accepting requests
        ST_FILL  = 2'd2,  // line refill over the read burst
        ST_RECHK = 2'd3   // one-cycle tag re-check after refill
    } ic_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/icache_tags.sv
// Tag and valid store, one bank per way.
// Assumes: clear and fill never target the same way and set in one cycle
// (the controller issues them in different states). Valid bits are not reset;
// the controller's walk clears them before any lookup.
module icache_tags #(
    parameter int WAYS  = 2,
    parameter int LINES = 64,
    parameter int TAG_W = 21,
    localparam int IDX_W = $clog2(LINES),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic [WAYS-1:0]  hit_o,
    output logic [WAYS-1:0]  vld_o
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic             valid_r [LINES];
        logic [TAG_W-1:0] tag_r   [LINES];

        // Clear a set (walk or invalidate) or install a refilled tag.
        always_ff @(posedge clk) begin
            if (clr_en) begin
                valid_r[clr_idx] <= 1'b0;
            end else if (fill_en && fill_way == WAY_W'(g)) begin
                valid_r[fill_idx] <= 1'b1;
                tag_r[fill_idx]   <= fill_tag;
            end
        end

        // Compare the held address against this way.
        assign vld_o[g] = valid_r[look_idx];
        assign hit_o[g] = valid_r[look_idx] && (tag_r[look_idx] == look_tag);
    end
endmodule

// File: rtl/icache_data.sv
// Instruction word store, one bank per way, one write port and
// asynchronous read of all ways at the same index.
module icache_data #(
    parameter int WAYS   = 2,
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [AW-1:0]                rd_addr,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data
);
    for (genvar g = 0; g < WAYS; g++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Store one refill beat into the selected way.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(g)) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rd_data[g] = mem[rd_addr];
    end
endmodule

// File: rtl/icache_victim.sv
// Victim way choice: lowest empty way of the set, else a free-running
// counter. Keeps no record of use.
module icache_victim #(
    parameter int WAYS = 2,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  vld_i,
    output logic [WAY_W-1:0] way_o
);
    logic [WAY_W-1:0] cnt_q;

    // Advance the pseudo-random pointer every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Prefer the lowest empty way, otherwise the counter.
    always_comb begin
        way_o = cnt_q;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld_i[i]) way_o = WAY_W'(i);
        end
    end
endmodule

// File: rtl/icache_ctrl.sv
// Read-only set-associative instruction cache controller.
// Fetch side: request/accept, then valid with the word one cycle after
// acceptance on a hit. Memory side: AXI4 read address/data channels only,
// one incrementing burst per line refill, read-data ready tied high.
// Assumes the memory never returns beats before the address handshake and
// ends every burst with the last-beat flag after LINE_WORDS beats.
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 2,
    parameter int LINES      = 64,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_rd_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic              fetch_flush_i,
    input  logic              fetch_inval_i,
    output logic              fetch_accept_o,
    output logic              fetch_valid_o,
    output logic [DATA_W-1:0] fetch_data_o,
    output logic              m_arvalid_o,
    input  logic              m_arready_i,
    output logic [ADDR_W-1:0] m_araddr_o,
    output logic [7:0]        m_arlen_o,
    output logic [2:0]        m_arsize_o,
    output logic [1:0]        m_arburst_o,
    input  logic              m_rvalid_i,
    input  logic [DATA_W-1:0] m_rdata_i,
    input  logic              m_rlast_i,
    output logic              m_rready_o
);
    localparam int BYTE_W  = $clog2(DATA_W / 8);
    localparam int WORD_W  = $clog2(LINE_WORDS);
    localparam int OFF_W   = BYTE_W + WORD_W;
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int DEPTH   = LINES * LINE_WORDS;
    localparam int DADDR_W = IDX_W + WORD_W;

    ic_state_e                 state_q;
    logic [IDX_W-1:0]          walk_idx_q;
    logic                      pend_q;
    logic [ADDR_W-1:BYTE_W]    addr_q;
    logic                      arvalid_q;
    logic [WORD_W-1:0]         beat_q;
    logic [WAY_W-1:0]          victim_q;

    logic [IDX_W-1:0]          look_idx;
    logic [TAG_W-1:0]          look_tag;
    logic [WORD_W-1:0]         look_word;
    logic [IDX_W-1:0]          req_idx;
    logic [WAYS-1:0]           hit_vec;
    logic [WAYS-1:0]           vld_vec;
    logic                      hit;
    logic                      look_ready;
    logic                      take_flush;
    logic                      take_inval;
    logic                      take_read;
    logic                      clr_en;
    logic [IDX_W-1:0]          clr_idx;
    logic                      fill_en;
    logic                      beat_en;
    logic [WAY_W-1:0]          pick_way;
    logic [WAYS-1:0][DATA_W-1:0] way_words;
    logic [DATA_W-1:0]         sel_word;
    logic                      unused_lsb;

    assign look_idx   = addr_q[OFF_W +: IDX_W];
    assign look_tag   = addr_q[ADDR_W-1 -: TAG_W];
    assign look_word  = addr_q[BYTE_W +: WORD_W];
    assign req_idx    = fetch_addr_i[OFF_W +: IDX_W];
    assign unused_lsb = ^fetch_addr_i[BYTE_W-1:0];
    assign hit        = |hit_vec;

    // Lookup can take a new command unless a held request just missed.
    assign look_ready = (state_q == ST_LOOK) && !(pend_q && !hit);
    assign take_flush = look_ready && fetch_flush_i;
    assign take_inval = look_ready && !fetch_flush_i && fetch_inval_i;
    assign take_read  = look_ready && !fetch_flush_i && !fetch_inval_i && fetch_rd_i;

    assign fetch_accept_o = look_ready && !fetch_flush_i && !fetch_inval_i;
    assign fetch_valid_o  = pend_q && hit && (state_q == ST_LOOK || state_q == ST_RECHK);
    assign fetch_data_o   = sel_word;

    // Tag store write controls: walk / invalidate clears, refill installs.
    assign clr_en  = (state_q == ST_WALK) || take_inval;
    assign clr_idx = (state_q == ST_WALK) ? walk_idx_q : req_idx;
    assign beat_en = (state_q == ST_FILL) && m_rvalid_i;
    assign fill_en = beat_en && m_rlast_i;

    icache_tags #(
        .WAYS (WAYS),
        .LINES(LINES),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .fill_en (fill_en),
        .fill_way(victim_q),
        .fill_idx(look_idx),
        .fill_tag(look_tag),
        .look_idx(look_idx),
        .look_tag(look_tag),
        .hit_o   (hit_vec),
        .vld_o   (vld_vec)
    );

    icache_data #(
        .WAYS  (WAYS),
        .DEPTH (DEPTH),
        .DATA_W(DATA_W)
    ) u_data (
        .clk    (clk),
        .wr_en  (beat_en),
        .wr_way (victim_q),
        .wr_addr(DADDR_W'({look_idx, beat_q})),
        .wr_data(m_rdata_i),
        .rd_addr(DADDR_W'({look_idx, look_word})),
        .rd_data(way_words)
    );

    icache_victim #(
        .WAYS(WAYS)
    ) u_victim (
        .clk  (clk),
        .rst_n(rst_n),
        .vld_i(vld_vec),
        .way_o(pick_way)
    );

    // Route the word of the hitting way to the output.
    always_comb begin
        sel_word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) sel_word = sel_word | way_words[w];
        end
    end

    // Main sequencer: walk, lookup, refill, re-check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_WALK;
            walk_idx_q <= '0;
            pend_q     <= 1'b0;
            addr_q     <= '0;
            arvalid_q  <= 1'b0;
            beat_q     <= '0;
            victim_q   <= '0;
        end else begin
            case (state_q)
                ST_WALK: begin
                    pend_q     <= 1'b0;
                    walk_idx_q <= walk_idx_q + 1'b1;
                    if (walk_idx_q == IDX_W'(LINES - 1)) state_q <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (pend_q && !hit) begin
                        state_q   <= ST_FILL;
                        arvalid_q <= 1'b1;
                        beat_q    <= '0;
                        victim_q  <= pick_way;
                    end else begin
                        if (pend_q) pend_q <= 1'b0;
                        if (take_flush) begin
                            state_q    <= ST_WALK;
                            walk_idx_q <= '0;
                        end else if (take_read) begin
                            addr_q <= fetch_addr_i[ADDR_W-1:BYTE_W];
                            pend_q <= 1'b1;
                        end
                    end
                end
                ST_FILL: begin
                    if (arvalid_q && m_arready_i) arvalid_q <= 1'b0;
                    if (beat_en) beat_q <= beat_q + 1'b1;
                    if (fill_en) state_q <= ST_RECHK;
                end
                ST_RECHK: begin
                    if (hit) pend_q <= 1'b0;
                    state_q <= ST_LOOK;
                end
                default: state_q <= ST_WALK;
            endcase
        end
    end

    assign m_arvalid_o = arvalid_q;
    assign m_araddr_o  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign m_arlen_o   = 8'(LINE_WORDS - 1);
    assign m_arsize_o  = 3'(BYTE_W);
    assign m_arburst_o = BURST_INCR;
    assign m_rready_o  = 1'b1;
endmodule

// File: rtl/icache_ctrl_chk.sv
// Protocol and sequencing checker for icache_ctrl, attached by bind.
// Observes ports only; keeps its own outstanding flag and reset-age counter.
module icache_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int LINES  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_rd_i,
    input logic              fetch_accept_o,
    input logic              fetch_valid_o,
    input logic              m_arvalid_o,
    input logic              m_arready_i,
    input logic [ADDR_W-1:0] m_araddr_o
);
    localparam int CW = $clog2(LINES) + 1;

    logic          out_q;
    logic [CW-1:0] age_q;

    // Track whether an accepted fetch still awaits its word.
    always_ff @(posedge clk) begin
        if (!rst_n)                          out_q <= 1'b0;
        else if (fetch_rd_i && fetch_accept_o) out_q <= 1'b1;
        else if (fetch_valid_o)              out_q <= 1'b0;
    end

    // Count clocks since reset, saturating at LINES.
    always_ff @(posedge clk) begin
        if (!rst_n)                    age_q <= '0;
        else if (age_q < CW'(LINES))   age_q <= age_q + 1'b1;
    end

    AST_WALK_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < CW'(LINES)) |-> (!fetch_accept_o && !m_arvalid_o)); // R1
    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> out_q); // R2
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid_o && !m_arready_i) |=> (m_arvalid_o && $stable(m_araddr_o))); // R4
    AST_AR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid_o && m_arready_i) |=> !m_arvalid_o); // R4
    AST_NO_VALID_IN_AR: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid_o |-> !fetch_valid_o); // R5
    AST_NO_ACCEPT_IN_AR: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid_o |-> !fetch_accept_o); // R6
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_rd_i && fetch_accept_o) |-> (!out_q || fetch_valid_o)); // R6
endmodule

bind icache_ctrl icache_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .LINES (LINES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_rd_i    (fetch_rd_i),
    .fetch_accept_o(fetch_accept_o),
    .fetch_valid_o (fetch_valid_o),
    .m_arvalid_o   (m_arvalid_o),
    .m_arready_i   (m_arready_i),
    .m_araddr_o    (m_araddr_o)
);

// File: tb/sim_icache_ctrl.sv
module sim_icache_ctrl;
    localparam int CLK_P = 10;
    localparam int LINES = 64;
    localparam int WORDS = 8;
    localparam logic [31:0] REG1 = 32'h0000_0800;
    localparam logic [31:0] REG2 = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] addr = '0;
    logic        flush = 1'b0;
    logic        inval = 1'b0;
    logic        accept, valid;
    logic [31:0] data;
    logic        arvalid;
    logic        arready = 1'b0;
    logic [31:0] araddr;
    logic [7:0]  arlen;
    logic [2:0]  arsize;
    logic [1:0]  arburst;
    logic        rvalid = 1'b0;
    logic [31:0] rdata = '0;
    logic        rlast = 1'b0;
    logic        rready;

    int          total = 0;
    int          bad = 0;
    longint      cyc = 0;
    int          ar_cnt = 0;
    int          ar_delay = 0;
    bit          rgap = 1'b0;
    longint      last_cyc = 0;
    logic [31:0] last_ar = '0;

    icache_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_rd_i(rd), .fetch_addr_i(addr), .fetch_flush_i(flush), .fetch_inval_i(inval),
        .fetch_accept_o(accept), .fetch_valid_o(valid), .fetch_data_o(data),
        .m_arvalid_o(arvalid), .m_arready_i(arready), .m_araddr_o(araddr),
        .m_arlen_o(arlen), .m_arsize_o(arsize), .m_arburst_o(arburst),
        .m_rvalid_i(rvalid), .m_rdata_i(rdata), .m_rlast_i(rlast), .m_rready_o(rready)
    );

    always #(CLK_P / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1234_ABCD;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Memory model: address handshake after ar_delay cycles, 8 beats, optional gaps.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && arvalid) begin
                logic [31:0] a0;
                a0 = araddr;
                chk(a0[4:0] == 5'd0 && arlen == 8'd7 && arsize == 3'd2 && arburst == 2'b01
                    && rready, "R3", "burst fields", {arlen, 3'b0, arsize, 6'b0, arburst, a0[4:0]},
                    {8'd7, 3'b0, 3'd2, 6'b0, 2'b01, 5'd0});
                for (int d = 0; d < ar_delay; d++) begin
                    @(negedge clk);
                    chk(arvalid && araddr == a0, "R4", "address held", araddr, a0);
                end
                arready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                arready = 1'b0;
                ar_cnt++;
                last_ar = a0;
                for (int b = 0; b < WORDS; b++) begin
                    if (rgap && (b % 2 == 1)) @(negedge clk);
                    rvalid = 1'b1;
                    rdata  = mem_word(a0 + 32'(4 * b));
                    rlast  = (b == WORDS - 1);
                    @(posedge clk);
                    @(negedge clk);
                    rvalid = 1'b0;
                    rlast  = 1'b0;
                end
                last_cyc = cyc;
            end
        end
    end

    // One fetch; checks latency, data and burst activity against hit/miss expectation.
    task automatic do_read(input logic [31:0] a, input bit exp_hit, input string req);
        int     ar0;
        int     n;
        bit     acc_seen;
        longint vcyc;
        ar0 = ar_cnt;
        rd = 1'b1;
        addr = a;
        #1;
        while (!accept) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        n = 0;
        acc_seen = 1'b0;
        while (!valid && n < 400) begin
            if (accept) acc_seen = 1'b1;
            @(negedge clk);
            n++;
        end
        vcyc = cyc;
        chk(valid && data == mem_word({a[31:2], 2'b00}), req, "word", data, mem_word({a[31:2], 2'b00}));
        #1;
        if (exp_hit) begin
            chk(n == 0, "R2", "hit latency", 32'(n), 32'd0);
            chk(ar_cnt == ar0, "R2", "no burst on hit", 32'(ar_cnt - ar0), 32'd0);
        end else begin
            chk(ar_cnt == ar0 + 1, "R4", "one burst per miss", 32'(ar_cnt - ar0), 32'd1);
            chk(last_ar == {a[31:5], 5'd0}, "R3", "line address", last_ar, {a[31:5], 5'd0});
            chk(vcyc == last_cyc, "R5", "valid after last beat", 32'(vcyc), 32'(last_cyc));
            chk(!acc_seen, "R6", "accept low during miss", 32'(acc_seen), 32'd0);
        end
    endtask

    // Counts rising edges until accept, starting in the walk; checks no valid appears.
    task automatic walk_len(output int n, output bit vseen);
        n = 0;
        vseen = 1'b0;
        while (!accept && n < 500) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (valid || arvalid) vseen = 1'b1;
        end
    endtask

    initial begin
        int n;
        bit vs;
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        bit vs;
        repeat (4) @(negedge clk);
        chk(!accept && !valid && !arvalid && rready, "R1", "outputs in reset",
            {29'b0, accept, valid, arvalid}, 32'd0);
        rst_n = 1'b1;
        walk_len(n, vs);
        chk(n == LINES, "R1", "reset walk length", 32'(n), 32'(LINES));
        chk(!vs, "R1", "quiet during walk", 32'(vs), 32'd0);

        // Sweep all sets: miss then every word hits.
        for (int i = 0; i < LINES; i++) begin
            ar_delay = i % 4;
            rgap = (i % 3 == 0);
            do_read(32'(i * 32 + 12), 1'b0, "R5");
            for (int w = 0; w < WORDS; w++) do_read(32'(i * 32 + w * 4), 1'b1, "R2");
        end
        // Second tag per set, then both tags resident.
        for (int i = 0; i < LINES; i++) begin
            rgap = (i % 2 == 1);
            do_read(REG1 + 32'(i * 32 + 28), 1'b0, "R5");
        end
        for (int i = 0; i < LINES; i++) begin
            do_read(32'(i * 32 + 4), 1'b1, "R9");
            do_read(REG1 + 32'(i * 32 + 8), 1'b1, "R9");
        end

        // Invalidate set 20 in the same cycle as a hit on set 10, with a read offered.
        rd = 1'b1;
        addr = 32'(10 * 32);
        #1;
        while (!accept) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        inval = 1'b1;
        rd = 1'b1;
        addr = 32'(20 * 32 + 4);
        #1;
        chk(valid && data == mem_word(32'(10 * 32)), "R10", "hit beside invalidate",
            data, mem_word(32'(10 * 32)));
        chk(!accept, "R8", "read refused with invalidate", 32'(accept), 32'd0);
        @(posedge clk);
        @(negedge clk);
        inval = 1'b0;
        rd = 1'b0;
        #1;
        chk(!valid, "R8", "no response to refused read", 32'(valid), 32'd0);
        do_read(REG1 + 32'(20 * 32), 1'b0, "R8");
        do_read(32'(20 * 32), 1'b0, "R8");
        do_read(32'(21 * 32), 1'b1, "R8");
        do_read(REG1 + 32'(19 * 32), 1'b1, "R8");

        // Third tag per set replaces one way and then hits.
        for (int i = 0; i < LINES; i++) begin
            ar_delay = (i % 2 == 0) ? 3 : 0;
            do_read(REG2 + 32'(i * 32 + 16), 1'b0, "R9");
            do_read(REG2 + 32'(i * 32 + 20), 1'b1, "R9");
        end

        // Flush in the same cycle as a hit response, with a read offered.
        rd = 1'b1;
        addr = REG2;
        #1;
        while (!accept) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        flush = 1'b1;
        rd = 1'b1;
        addr = 32'h40;
        #1;
        chk(valid && data == mem_word(REG2), "R10", "hit beside flush", data, mem_word(REG2));
        chk(!accept, "R7", "read refused with flush", 32'(accept), 32'd0);
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        rd = 1'b0;
        walk_len(n, vs);
        chk(n == LINES, "R7", "flush walk length", 32'(n), 32'(LINES));
        chk(!vs, "R7", "quiet during flush walk", 32'(vs), 32'd0);
        ar_delay = 1;
        do_read(REG2, 1'b0, "R7");
        do_read(REG2 + 32'(5 * 32), 1'b0, "R7");
        do_read(32'(33 * 32), 1'b0, "R7");
        do_read(REG2 + 32'(5 * 32 + 4), 1'b1, "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule